// File: doc/BRIEF.md
# Watchdog Wake-Up and Reset Sequencer

This block drives a periodic wake-up square wave that rouses a sleeping processor, and it watches a watchdog line that the processor must pulse once per wake-up period. A falling edge on the watchdog line serves the current period and pulls the wake-up output low for the rest of that period. A period that passes with no falling edge ends in a reset pulse. A power-good flag from the supply monitor holds the reset output low while the supply is out of regulation.

Every delay is a fixed multiple of one unit T. T is a parameter counted in strobes of a shared prescale tick. The reset release delay is 5T. The delay from reset release to the first wake-up is 20T. The wake-up period is 40T, split 20T high and 20T low. Because all three come from one time base, their ratios do not change when the tick rate changes.

Top module: `wdt_wake_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards for as long as `pwr_ok` stays low, `rst_out_n` is 0 and `wake` is 0.
- R2: Once `pwr_ok` is high, `rst_out_n` goes to 1 on the clock that carries the 5·T_TICKS-th tick. Ticks are counted from the clock after the one that first samples `pwr_ok` high.
- R3: After `rst_out_n` rises, `wake` stays 0 for exactly 20·T_TICKS ticks and then rises to start a wake-up period.
- R4: In a period whose only watchdog edge falls in the low phase, `wake` is 1 for 20·T_TICKS ticks and 0 for 20·T_TICKS ticks. `rst_out_n` stays 1 and the next period starts at once.
- R5: `wdi` passes through a two-flop synchronizer. A falling edge is a sampled 1 followed by a sampled 0. The first such edge in a period drives `wake` to 0 within 4 clocks. `wake` then stays 0 until the next period starts, and the period length stays 40·T_TICKS ticks.
- R6: Further `wdi` falling edges in the same period change nothing: `wake` stays 0, the period ends on time and no reset follows.
- R7: A period with no `wdi` falling edge ends with `rst_out_n` going to 0 at the period's end. It stays 0 for 5·T_TICKS ticks, and then the R3 sequence follows.
- R8: `wake` is 0 in every clock in which `rst_out_n` is 0.
- R9: `pwr_ok` low in any state drives `rst_out_n` to 0 on the next clock. `rst_out_n` stays 0 while `pwr_ok` is low and is released as in R2.
- R10: Timers advance only on clocks with `tick` high. With ticks k clocks apart, every duration in clocks is k times its tick count, and with no ticks no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Prescale strobe; one high clock per time-base tick |
| wdi | input | 1 | Watchdog input from the processor, asynchronous |
| pwr_ok | input | 1 | Supply-in-regulation flag, synchronous |
| rst_out_n | output | 1 | Active-low reset to the processor |
| wake | output | 1 | Wake-up square wave |

## Verification
The hardest case to reach is a period cut short by a watchdog edge and then hit by more edges. It only shows whether the later edges are really ignored if the period still ends on its original tick and no reset follows. The bench times the high phase up to the first edge and places two more edges in the low phase. It then requires the low phase to last exactly the rest of 40T, with the reset output high throughout. It repeats this at three tick spacings, so an off-by-one in tick gating scales with the spacing and cannot hide.

// File: rtl/wst_pkg.sv
package wst_pkg;

  typedef enum logic [1:0] {
    ST_PWR_WAIT = 2'd0,
    ST_RST_HOLD = 2'd1,
    ST_WAKE_DLY = 2'd2,
    ST_CYCLE    = 2'd3
  } wst_state_e;

  localparam int unsigned RST_UNITS    = 5;
  localparam int unsigned WAKE_DLY_UNITS = 20;
  localparam int unsigned PERIOD_UNITS = 40;

endpackage

// File: rtl/wst_wdi_edge.sv
module wst_wdi_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi_i,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], wdi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  // a detected edge is a single-cycle event
  p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/wst_interval.sv
module wst_interval #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = tick_i && (cnt_q == limit_i - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || done_o) cnt_d = '0;
    else if (tick_i)     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // counter never passes the interval it is timing
  p_cnt_below_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q < limit_i) || $changed(limit_i));

  // without a tick the count holds
  p_cnt_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_wake_seq.sv
module wdt_wake_seq
  import wst_pkg::*;
#(
  parameter int unsigned T_TICKS  = 4,
  parameter int unsigned WDI_SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wdi,
  input  logic pwr_ok,
  output logic rst_out_n,
  output logic wake
);

  localparam int unsigned RST_TICKS    = RST_UNITS * T_TICKS;
  localparam int unsigned WDLY_TICKS   = WAKE_DLY_UNITS * T_TICKS;
  localparam int unsigned PERIOD_TICKS = PERIOD_UNITS * T_TICKS;
  localparam int unsigned HALF_TICKS   = PERIOD_TICKS / 2;
  localparam int unsigned CW           = $clog2(PERIOD_TICKS + 1);

  wst_state_e    state_q, state_d;
  logic          served_q, served_d;
  logic          fall;
  logic          done;
  logic          clr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  wst_wdi_edge #(.STAGES(WDI_SYNC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .wdi_i  (wdi),
    .fall_o (fall)
  );

  always_comb begin
    case (state_q)
      ST_RST_HOLD: limit = CW'(RST_TICKS);
      ST_WAKE_DLY: limit = CW'(WDLY_TICKS);
      default:     limit = CW'(PERIOD_TICKS);
    endcase
  end

  assign clr = (state_d != state_q);

  wst_interval #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .tick_i  (tick),
    .limit_i (limit),
    .cnt_o   (cnt),
    .done_o  (done)
  );

  always_comb begin
    state_d  = state_q;
    served_d = served_q;
    if (!pwr_ok) begin
      state_d  = ST_PWR_WAIT;
      served_d = 1'b0;
    end else begin
      case (state_q)
        ST_PWR_WAIT: state_d = ST_RST_HOLD;
        ST_RST_HOLD: if (done) state_d = ST_WAKE_DLY;
        ST_WAKE_DLY: if (done) begin
          state_d  = ST_CYCLE;
          served_d = 1'b0;
        end
        ST_CYCLE: begin
          if (fall) served_d = 1'b1;
          if (done) begin
            served_d = 1'b0;
            if (!(served_q || fall)) state_d = ST_RST_HOLD;
          end
        end
        default: state_d = ST_PWR_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_PWR_WAIT;
      served_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      served_q <= served_d;
    end
  end

  assign rst_out_n = (state_q == ST_WAKE_DLY) || (state_q == ST_CYCLE);
  assign wake      = (state_q == ST_CYCLE) && !served_q && (cnt < CW'(HALF_TICKS));

  p_wake_quiet_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> !wake);

  p_pwr_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !rst_out_n);

  p_release_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(pwr_ok));

  p_edge_drops_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CYCLE && fall && !done && pwr_ok) |=> !wake);

  p_missed_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CYCLE && done && !served_q && !fall && pwr_ok) |=> !rst_out_n);

endmodule

// File: tb/wdt_wake_seq_bench.sv
`timescale 1ns/1ps
module wdt_wake_seq_bench;

  localparam int T_TICKS = 2;
  localparam int RSTT    = 5 * T_TICKS;
  localparam int WDLY    = 20 * T_TICKS;
  localparam int HALF    = 20 * T_TICKS;
  localparam int PERIOD  = 40 * T_TICKS;
  localparam int NONE    = -10;

  logic clk = 1'b0;
  logic rst_n, tick, wdi, pwr_ok;
  logic rst_out_n, wake;

  int  div = 1;
  int  tc = 0;
  bit  tick_run = 1'b0;
  int  checks = 0;
  int  fails = 0;

  always #2 clk = ~clk;

  wdt_wake_seq #(.T_TICKS(T_TICKS)) u_wdt_wake_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wdi       (wdi),
    .pwr_ok    (pwr_ok),
    .rst_out_n (rst_out_n),
    .wake      (wake)
  );

  always @(negedge clk) begin
    if (!tick_run) tick <= 1'b0;
    else begin
      tick <= (tc == 0);
      tc   <= (tc + 1 >= div) ? 0 : tc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tick spacing %0d)", req, act, exp, div);
    end
  endtask

  // counts clocks until the chosen output reaches target, pulsing wdi low at f1/f2
  task automatic run_until(input bit use_wake, input bit target, input int f1, input int f2,
                           output int n, output bit rst_low, output bit wake_hi);
    n = 0; rst_low = 1'b0; wake_hi = 1'b0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == f1 || n == f2) wdi = 1'b0;
      if (n == f1 + 3 || n == f2 + 3) wdi = 1'b1;
      if (!rst_out_n) rst_low = 1'b1;
      if (wake) wake_hi = 1'b1;
      if ((use_wake ? wake : rst_out_n) == target) break;
      if (n > 5000) break;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, n1;
    bit rl, wh, all_hi;
    rst_n = 1'b0; pwr_ok = 1'b0; wdi = 1'b1;
    for (int d = 1; d <= 3; d++) begin
      div = d; tick_run = 1'b1;
      rst_n = 1'b0; pwr_ok = 1'b0; wdi = 1'b1;
      repeat (3) @(negedge clk);
      chk(rst_out_n == 0 && wake == 0, "R1 in reset", int'({rst_out_n, wake}), 0);
      rst_n = 1'b1;
      repeat (12) @(negedge clk);
      chk(rst_out_n == 0 && wake == 0, "R1 pwr_ok low", int'({rst_out_n, wake}), 0);

      pwr_ok = 1'b1;
      run_until(0, 1, NONE, NONE, n, rl, wh);
      chk(n >= 2 + (RSTT - 1) * d && n <= 1 + RSTT * d, "R2 release delay", n, RSTT * d);
      run_until(1, 1, NONE, NONE, n, rl, wh);
      chk(n == WDLY * d, "R3 wake delay", n, WDLY * d);
      chk(!rl, "R3 reset stays high", int'(rl), 0);

      run_until(1, 0, NONE, NONE, n, rl, wh);
      chk(n == HALF * d, "R4 high phase", n, HALF * d);
      run_until(1, 1, 6, NONE, n, rl, wh);
      chk(n == HALF * d, "R4 low phase", n, HALF * d);
      chk(!rl, "R4 served period no reset", int'(rl), 0);

      run_until(1, 0, 5, NONE, n1, rl, wh);
      chk(n1 >= 6 && n1 <= 9, "R5 edge ends high phase", n1, 8);
      run_until(1, 1, 4, 12, n, rl, wh);
      chk(n == PERIOD * d - n1, "R6 period unchanged by extra edges", n, PERIOD * d - n1);
      chk(!rl, "R6 extra edges cause no reset", int'(rl), 0);

      run_until(1, 0, NONE, NONE, n, rl, wh);
      chk(n == HALF * d, "R4 high phase before miss", n, HALF * d);
      run_until(0, 0, NONE, NONE, n, rl, wh);
      chk(n == HALF * d, "R7 reset at period end", n, HALF * d);
      chk(wake == 0, "R8 wake low at reset", int'(wake), 0);
      run_until(0, 1, NONE, NONE, n, rl, wh);
      chk(n == RSTT * d, "R7 reset pulse width", n, RSTT * d);
      chk(!wh, "R8 wake low during reset pulse", int'(wh), 0);
      run_until(1, 1, NONE, NONE, n, rl, wh);
      chk(n == WDLY * d, "R7 then R3 wake delay", n, WDLY * d);

      repeat (3) @(negedge clk);
      tick_run = 1'b0;
      all_hi = 1'b1;
      for (int k = 0; k < HALF * d * 3 + 20; k++) begin
        @(negedge clk);
        if (!(wake && rst_out_n)) all_hi = 1'b0;
      end
      chk(all_hi, "R10 no ticks no change", int'(all_hi), 1);
      tick_run = 1'b1;
      run_until(1, 0, NONE, NONE, n, rl, wh);
      chk(n > 0 && n <= HALF * d, "R10 resumes after ticks", n, HALF * d);

      @(negedge clk);
      pwr_ok = 1'b0;
      @(negedge clk);
      chk(rst_out_n == 0 && wake == 0, "R9 reset on pwr loss", int'({rst_out_n, wake}), 0);
      repeat (20) @(negedge clk);
      chk(rst_out_n == 0, "R9 held while pwr low", int'(rst_out_n), 0);
      pwr_ok = 1'b1;
      run_until(0, 1, NONE, NONE, n, rl, wh);
      chk(n >= 2 + (RSTT - 1) * d && n <= 1 + RSTT * d, "R9 release delay", n, RSTT * d);
      run_until(1, 1, NONE, NONE, n, rl, wh);
      chk(n == WDLY * d, "R3 wake delay after pwr return", n, WDLY * d);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule